// File: doc/BRIEF.md
# Temperature Sensor Command Register Bank

This block is the register side of a temperature sensor that sits on a two-wire management bus. A bus engine outside the block decodes the byte-level traffic. It hands over three kinds of event: a command byte, which moves a register pointer; a data byte to write at the pointer; and a read request, which returns the byte at the pointer. Because the pointer persists, the block serves all four transfer kinds. A send byte sets the pointer. A receive byte reads it. A write byte sets the pointer and then writes. A read byte sets the pointer and then reads.

The block holds the latest temperature sample, a status byte, a configuration byte, a conversion-rate byte and a pair of upper and lower limits. A scheduler starts conversions on a stubbed converter port. In running mode it starts them on a timer whose period comes from the rate byte. In stand-by mode it starts only one conversion per one-shot request. The channel is either fixed or rotated over the three inputs. Each returned sample is compared with the limits. A breach latches a status flag, and the flag pulls an active-low alert output unless the alert is masked. A status read releases the flags once the breach has passed.

Top module: `thermsense_regbank`

## Requirements
- R1: A `cmd_valid` pulse loads `cmd_code` into the pointer. A `rd_req` pulse returns the byte addressed by the pointer on `rd_data`, with `rd_valid` high, in the next cycle. Reads leave the pointer unchanged.
- R2: Read codes are 01h temperature, 02h status, 03h configuration, 04h rate, 07h upper limit and 08h lower limit. After reset they read 00h, 00h, 00h, 07h, 55h and 00h.
- R3: After reset the pointer holds the reserved code 00h. Reads of 00h, of the write codes and of any unmapped code return FFh and change no state.
- R4: Write codes are 09h configuration, 0Ah rate, 0Bh upper limit, 0Ch lower limit and 0Fh one-shot. A write to a read code or to an unmapped code changes nothing.
- R5: Configuration bit 6 set selects stand-by, and no timed conversion starts while it is set. A write of any byte to 0Fh starts exactly one conversion when the converter is idle.
- R6: Rate bits 5:4 select the channel: 00 rotates, 01 local, 10 remote 1, 11 remote 2. `conv_chan` carries the same code during a conversion. The rotation runs 01, 10, 11, 01, and so on.
- R7: In running mode, timed starts are FAST_PERIOD << (RATE_MAX − min(code, RATE_MAX)) cycles apart, where code is rate bits 3:0.
- R8: Status bit 7 is high from the `conv_start` cycle until the cycle after `conv_done`. No conversion starts while it is high.
- R9: Each accepted sample is stored as the temperature. Status bit 4 is set when the sample is above the upper limit, and bit 3 when it is below the lower limit. All other status bits read 0.
- R10: Bits 4 and 3 stay set after the breach ends. A status read returns them, and they then take the value of the breach test on the stored temperature.
- R11: `alert_n` is low while bit 4 or bit 3 is set and configuration bit 7 is clear. Setting configuration bit 7 holds `alert_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 8 | Data byte to write at the pointer |
| rd_req | input | 1 | Read request at the pointer |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 2 | Channel of the current conversion |
| conv_done | input | 1 | Converter result strobe |
| conv_temp | input | 8 | Converter result, unsigned |
| alert_n | output | 1 | Active-low limit alert |

## Verification
The bench uses the default parameters: FAST_PERIOD of 16, RATE_MAX of 8 and strict limit comparison. With these values the reset rate code 07h gives a 32-cycle interval, code 08h gives 16 cycles, code 0Fh clamps to 16 cycles, and code 06h gives 64 cycles. All of these intervals are short enough to measure directly. The converter model answers six cycles after a start. That is long enough to read the busy bit in the middle of a conversion, and short enough that timed starts are never held back. The 32-cycle first interval also leaves room to read every reset value before the first sample lands.

// File: rtl/thermsense_pkg.sv
package thermsense_pkg;

   // Read command codes
   localparam logic [7:0] CMD_RESERVED = 8'h00;
   localparam logic [7:0] RD_TEMP      = 8'h01;
   localparam logic [7:0] RD_STATUS    = 8'h02;
   localparam logic [7:0] RD_CONFIG    = 8'h03;
   localparam logic [7:0] RD_RATE      = 8'h04;
   localparam logic [7:0] RD_HIGH      = 8'h07;
   localparam logic [7:0] RD_LOW       = 8'h08;

   // Write command codes
   localparam logic [7:0] WR_CONFIG    = 8'h09;
   localparam logic [7:0] WR_RATE      = 8'h0A;
   localparam logic [7:0] WR_HIGH      = 8'h0B;
   localparam logic [7:0] WR_LOW       = 8'h0C;
   localparam logic [7:0] WR_ONESHOT   = 8'h0F;

   // Bit positions
   localparam int CFG_MASK_BIT    = 7;
   localparam int CFG_STANDBY_BIT = 6;

   typedef enum logic [1:0] {
      CH_ROTATE = 2'b00,
      CH_LOCAL  = 2'b01,
      CH_REM1   = 2'b10,
      CH_REM2   = 2'b11
   } chan_e;

endpackage

// File: rtl/thermsense_cmdregs.sv
module thermsense_cmdregs
   import thermsense_pkg::*;
#(
   parameter logic [7:0] RST_CONFIG = 8'h00,
   parameter logic [7:0] RST_RATE   = 8'h07,
   parameter logic [7:0] RST_HIGH   = 8'h55,
   parameter logic [7:0] RST_LOW    = 8'h00,
   parameter logic [7:0] READ_FILL  = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   input  logic       wr_valid,
   input  logic [7:0] wr_data,
   input  logic       rd_req,
   input  logic [7:0] temp_i,
   input  logic [7:0] status_i,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic [7:0] ptr_o,
   output logic       standby_o,
   output logic       mask_o,
   output logic [3:0] rate_code_o,
   output logic [1:0] chan_sel_o,
   output logic [7:0] high_o,
   output logic [7:0] low_o,
   output logic       oneshot_o,
   output logic       status_rd_o
);

   logic [7:0] ptr_q, cfg_q, rate_q, high_q, low_q;
   logic [7:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= CMD_RESERVED;
         cfg_q  <= RST_CONFIG;
         rate_q <= RST_RATE;
         high_q <= RST_HIGH;
         low_q  <= RST_LOW;
      end else begin
         if (cmd_valid) ptr_q <= cmd_code;
         if (wr_valid) begin
            case (ptr_q)
               WR_CONFIG: cfg_q  <= wr_data;
               WR_RATE:   rate_q <= wr_data;
               WR_HIGH:   high_q <= wr_data;
               WR_LOW:    low_q  <= wr_data;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      case (ptr_q)
         RD_TEMP:   rd_mux = temp_i;
         RD_STATUS: rd_mux = status_i;
         RD_CONFIG: rd_mux = cfg_q;
         RD_RATE:   rd_mux = rate_q;
         RD_HIGH:   rd_mux = high_q;
         RD_LOW:    rd_mux = low_q;
         default:   rd_mux = READ_FILL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 8'h00;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) rd_data <= rd_mux;
      end
   end

   assign ptr_o       = ptr_q;
   assign standby_o   = cfg_q[CFG_STANDBY_BIT];
   assign mask_o      = cfg_q[CFG_MASK_BIT];
   assign rate_code_o = rate_q[3:0];
   assign chan_sel_o  = rate_q[5:4];
   assign high_o      = high_q;
   assign low_o       = low_q;
   assign oneshot_o   = wr_valid && (ptr_q == WR_ONESHOT);
   assign status_rd_o = rd_req && (ptr_q == RD_STATUS);

endmodule

// File: rtl/thermsense_sched.sv
module thermsense_sched
   import thermsense_pkg::*;
#(
   parameter int FAST_PERIOD = 16,
   parameter int RATE_MAX    = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       oneshot,
   input  logic [3:0] rate_code,
   input  logic [1:0] chan_sel,
   input  logic       conv_done,
   output logic       conv_start,
   output logic [1:0] conv_chan,
   output logic       busy,
   output logic       accept
);

   localparam int CNT_W = $clog2(FAST_PERIOD) + RATE_MAX + 1;

   logic [CNT_W-1:0] cnt_q, period;
   logic [3:0]       eff_code;
   logic             busy_q, timer_hit, fire;
   chan_e            rr_q, rr_next, chan_q;

   assign eff_code  = (rate_code > 4'(RATE_MAX)) ? 4'(RATE_MAX) : rate_code;
   assign period    = CNT_W'(FAST_PERIOD) << (4'(RATE_MAX) - eff_code);
   assign timer_hit = run && (cnt_q >= period - CNT_W'(1));
   assign fire      = !busy_q && (timer_hit || oneshot);
   assign accept    = conv_done && busy_q;

   always_comb begin
      case (rr_q)
         CH_LOCAL: rr_next = CH_REM1;
         CH_REM1:  rr_next = CH_REM2;
         default:  rr_next = CH_LOCAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         busy_q     <= 1'b0;
         conv_start <= 1'b0;
         rr_q       <= CH_LOCAL;
         chan_q     <= CH_LOCAL;
      end else begin
         conv_start <= fire;
         if (!run || fire)   cnt_q <= '0;
         else if (!timer_hit) cnt_q <= cnt_q + CNT_W'(1);
         if (fire) begin
            busy_q <= 1'b1;
            if (chan_e'(chan_sel) == CH_ROTATE) begin
               chan_q <= rr_q;
               rr_q   <= rr_next;
            end else begin
               chan_q <= chan_e'(chan_sel);
            end
         end else if (accept) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy      = busy_q;
   assign conv_chan = chan_q;

endmodule

// File: rtl/thermsense_status.sv
module thermsense_status #(
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] sample,
   input  logic       busy,
   input  logic [7:0] high_lim,
   input  logic [7:0] low_lim,
   input  logic       status_rd,
   input  logic       alert_mask,
   output logic [7:0] temp_o,
   output logic [7:0] status_o,
   output logic       alert_n
);

   logic [7:0] temp_q;
   logic       hi_q, lo_q, hi_d, lo_d;
   logic       samp_hi, samp_lo, cur_hi, cur_lo;

   generate
      if (INCLUSIVE) begin : g_incl
         assign samp_hi = sample >= high_lim;
         assign samp_lo = sample <= low_lim;
         assign cur_hi  = temp_q >= high_lim;
         assign cur_lo  = temp_q <= low_lim;
      end else begin : g_strict
         assign samp_hi = sample > high_lim;
         assign samp_lo = sample < low_lim;
         assign cur_hi  = temp_q > high_lim;
         assign cur_lo  = temp_q < low_lim;
      end
   endgenerate

   always_comb begin
      hi_d = status_rd ? cur_hi : hi_q;
      lo_d = status_rd ? cur_lo : lo_q;
      if (accept && samp_hi) hi_d = 1'b1;
      if (accept && samp_lo) lo_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp_q <= 8'h00;
         hi_q   <= 1'b0;
         lo_q   <= 1'b0;
      end else begin
         if (accept) temp_q <= sample;
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign temp_o   = temp_q;
   assign status_o = {busy, 2'b00, hi_q, lo_q, 3'b000};
   assign alert_n  = !((hi_q || lo_q) && !alert_mask);

endmodule

// File: rtl/thermsense_regbank.sv
module thermsense_regbank
   import thermsense_pkg::*;
#(
   parameter int         FAST_PERIOD      = 16,
   parameter int         RATE_MAX         = 8,
   parameter bit         INCLUSIVE_LIMITS = 1'b0,
   parameter logic [7:0] RST_RATE         = 8'h07,
   parameter logic [7:0] RST_HIGH         = 8'h55,
   parameter logic [7:0] RST_LOW          = 8'h00,
   parameter logic [7:0] READ_FILL        = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   input  logic       wr_valid,
   input  logic [7:0] wr_data,
   input  logic       rd_req,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic       conv_start,
   output logic [1:0] conv_chan,
   input  logic       conv_done,
   input  logic [7:0] conv_temp,
   output logic       alert_n
);

   generate
      if (FAST_PERIOD < 2) begin : g_bad_fast
         $error("FAST_PERIOD must be at least 2");
      end
      if (RATE_MAX < 0 || RATE_MAX > 15) begin : g_bad_rate
         $error("RATE_MAX must fit the 4-bit rate field");
      end
   endgenerate

   logic [7:0] temp_w, status_w, ptr_w, high_w, low_w;
   logic [3:0] rate_code_w;
   logic [1:0] chan_sel_w;
   logic       standby_w, mask_w, oneshot_w, status_rd_w, busy_w, accept_w;

   thermsense_cmdregs #(
      .RST_CONFIG (8'h00),
      .RST_RATE   (RST_RATE),
      .RST_HIGH   (RST_HIGH),
      .RST_LOW    (RST_LOW),
      .READ_FILL  (READ_FILL)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_code    (cmd_code),
      .wr_valid    (wr_valid),
      .wr_data     (wr_data),
      .rd_req      (rd_req),
      .temp_i      (temp_w),
      .status_i    (status_w),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .ptr_o       (ptr_w),
      .standby_o   (standby_w),
      .mask_o      (mask_w),
      .rate_code_o (rate_code_w),
      .chan_sel_o  (chan_sel_w),
      .high_o      (high_w),
      .low_o       (low_w),
      .oneshot_o   (oneshot_w),
      .status_rd_o (status_rd_w)
   );

   thermsense_sched #(
      .FAST_PERIOD (FAST_PERIOD),
      .RATE_MAX    (RATE_MAX)
   ) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (!standby_w),
      .oneshot    (oneshot_w),
      .rate_code  (rate_code_w),
      .chan_sel   (chan_sel_w),
      .conv_done  (conv_done),
      .conv_start (conv_start),
      .conv_chan  (conv_chan),
      .busy       (busy_w),
      .accept     (accept_w)
   );

   thermsense_status #(
      .INCLUSIVE (INCLUSIVE_LIMITS)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept_w),
      .sample     (conv_temp),
      .busy       (busy_w),
      .high_lim   (high_w),
      .low_lim    (low_w),
      .status_rd  (status_rd_w),
      .alert_mask (mask_w),
      .temp_o     (temp_w),
      .status_o   (status_w),
      .alert_n    (alert_n)
   );

endmodule

// File: rtl/thermsense_regbank_chk.sv
module thermsense_regbank_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_req,
   input logic       rd_valid,
   input logic       wr_valid,
   input logic       conv_start,
   input logic [1:0] conv_chan,
   input logic       conv_done,
   input logic       alert_n,
   input logic       busy,
   input logic       standby,
   input logic       oneshot,
   input logic [7:0] ptr,
   input logic [7:0] temp
);

   a_r1_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   a_r1_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   a_r4_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && ptr == 8'h01 && !(conv_done && busy)) |=> $stable(temp));

   a_r5_standby_no_timer: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !oneshot) |=> !conv_start);

   a_r6_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (conv_chan != 2'b00));

   a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !conv_start);

   a_r11_alert_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_n) |-> ($past(conv_done) || $past(wr_valid)));

   a_r10_alert_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert_n) |-> ($past(rd_req) || $past(wr_valid)));

endmodule

bind thermsense_regbank thermsense_regbank_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_req     (rd_req),
   .rd_valid   (rd_valid),
   .wr_valid   (wr_valid),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .conv_done  (conv_done),
   .alert_n    (alert_n),
   .busy       (busy_w),
   .standby    (standby_w),
   .oneshot    (oneshot_w),
   .ptr        (ptr_w),
   .temp       (temp_w)
);

// File: tb/thermsense_regbank_bench.sv
module thermsense_regbank_bench;

   localparam int LAT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = 8'h00;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_req = 1'b0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       conv_start;
   logic [1:0] conv_chan;
   logic       conv_done;
   logic [7:0] conv_temp;
   logic       alert_n;

   logic [7:0] tb_temp [4];
   logic [1:0] m_chan;
   int         m_lat;
   int         checks = 0;
   int         failures = 0;

   always #2.5 clk = ~clk;

   thermsense_regbank u_thermsense_regbank (
      .clk (clk), .rst_n (rst_n),
      .cmd_valid (cmd_valid), .cmd_code (cmd_code),
      .wr_valid (wr_valid), .wr_data (wr_data),
      .rd_req (rd_req), .rd_valid (rd_valid), .rd_data (rd_data),
      .conv_start (conv_start), .conv_chan (conv_chan),
      .conv_done (conv_done), .conv_temp (conv_temp),
      .alert_n (alert_n)
   );

   // Stub converter: answers LAT cycles after a start with the channel's value
   always @(posedge clk) begin
      if (!rst_n) begin
         conv_done <= 1'b0;
         conv_temp <= 8'h00;
         m_lat     <= 0;
         m_chan    <= 2'b00;
      end else begin
         conv_done <= 1'b0;
         if (m_lat != 0) begin
            m_lat <= m_lat - 1;
            if (m_lat == 1) begin
               conv_done <= 1'b1;
               conv_temp <= tb_temp[m_chan];
            end
         end else if (conv_start) begin
            m_lat  <= LAT;
            m_chan <= conv_chan;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_ptr(input logic [7:0] c);
      @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic rd_ptr(output logic [7:0] v, output logic vld);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0; v = rd_data; vld = rd_valid;
   endtask

   task automatic rd_code(input logic [7:0] c, output logic [7:0] v);
      logic vld;
      set_ptr(c);
      rd_ptr(v, vld);
   endtask

   task automatic wr_code(input logic [7:0] c, input logic [7:0] d);
      set_ptr(c);
      @(negedge clk); wr_valid = 1'b1; wr_data = d;
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic set_all(input logic [7:0] t);
      for (int i = 0; i < 4; i++) tb_temp[i] = t;
   endtask

   task automatic wait_start(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!conv_start && n < 20000);
   endtask

   task automatic oneshot_wait();
      wr_code(8'h0F, 8'h00);
      repeat (LAT + 6) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v; logic vld;
      chk(alert_n == 1'b1, "R11 alert_n idle after reset", alert_n, 1);
      chk(conv_start == 1'b0, "R8 no start at reset", conv_start, 0);
      rd_ptr(v, vld);
      chk(vld == 1'b1, "R1 rd_valid after request", vld, 1);
      chk(v == 8'hFF, "R3 reserved pointer after reset", v, 8'hFF);
      rd_code(8'h03, v); chk(v == 8'h00, "R2 config reset", v, 8'h00);
      rd_code(8'h04, v); chk(v == 8'h07, "R2 rate reset", v, 8'h07);
      rd_code(8'h07, v); chk(v == 8'h55, "R2 high reset", v, 8'h55);
      rd_code(8'h08, v); chk(v == 8'h00, "R2 low reset", v, 8'h00);
      rd_code(8'h01, v); chk(v == 8'h00, "R2 temp reset", v, 8'h00);
      rd_ptr(v, vld);    chk(v == 8'h00, "R1 pointer persists", v, 8'h00);
   endtask

   task automatic t_period();
      int n;
      wait_start(n);
      wait_start(n); chk(n == 32, "R7 interval at code 7", n, 32);
      wr_code(8'h0A, 8'h08);
      wait_start(n);
      wait_start(n); chk(n == 16, "R7 interval at code 8", n, 16);
      wr_code(8'h0A, 8'h0F);
      wait_start(n);
      wait_start(n); chk(n == 16, "R7 clamp at code F", n, 16);
      wr_code(8'h0A, 8'h06);
      wait_start(n);
      wait_start(n); chk(n == 64, "R7 interval at code 6", n, 64);
   endtask

   task automatic t_channel();
      int n; logic [1:0] prev, nxt;
      wr_code(8'h0A, 8'h07);
      wait_start(n);
      prev = conv_chan;
      chk(prev != 2'b00, "R6 rotating channel legal", prev, 1);
      for (int i = 0; i < 4; i++) begin
         wait_start(n);
         nxt = (prev == 2'b11) ? 2'b01 : prev + 2'd1;
         chk(conv_chan == nxt, "R6 rotation order", conv_chan, nxt);
         prev = conv_chan;
      end
      wr_code(8'h0A, 8'h27);
      wait_start(n);
      for (int i = 0; i < 3; i++) begin
         wait_start(n);
         chk(conv_chan == 2'b10, "R6 fixed remote 1", conv_chan, 2'b10);
      end
   endtask

   task automatic t_standby();
      int starts; logic [7:0] v;
      set_all(8'h30);
      wr_code(8'h09, 8'h40);
      repeat (LAT + 6) @(negedge clk);
      starts = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); if (conv_start) starts++;
      end
      chk(starts == 0, "R5 no timed starts in stand-by", starts, 0);
      set_all(8'h33);
      set_ptr(8'h0F);
      @(negedge clk); wr_valid = 1'b1;
      @(negedge clk); wr_valid = 1'b0;
      starts = conv_start ? 1 : 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); if (conv_start) starts++;
      end
      chk(starts == 1, "R5 one-shot gives one start", starts, 1);
      rd_code(8'h01, v); chk(v == 8'h33, "R9 one-shot sample stored", v, 8'h33);
   endtask

   task automatic t_busy();
      logic [7:0] v; logic vld;
      set_ptr(8'h0F);
      @(negedge clk); wr_valid = 1'b1;
      @(negedge clk); wr_valid = 1'b0;
      set_ptr(8'h02);
      rd_ptr(v, vld);
      chk(v[7] == 1'b1, "R8 busy during conversion", v, 8'h80);
      repeat (LAT + 6) @(negedge clk);
      rd_ptr(v, vld);
      chk(v == 8'h00, "R8 busy clear after result", v, 8'h00);
   endtask

   task automatic t_limits();
      logic [7:0] v;
      set_all(8'h5A);
      oneshot_wait();
      chk(alert_n == 1'b0, "R11 alert on upper breach", alert_n, 0);
      rd_code(8'h02, v); chk(v == 8'h10, "R9 upper flag", v, 8'h10);
      rd_code(8'h02, v); chk(v == 8'h10, "R10 flag kept while breach lasts", v, 8'h10);
      set_all(8'h28);
      oneshot_wait();
      chk(alert_n == 1'b0, "R10 alert latched after breach ends", alert_n, 0);
      rd_code(8'h02, v); chk(v == 8'h10, "R10 read returns latched flag", v, 8'h10);
      chk(alert_n == 1'b1, "R10 alert released by read", alert_n, 1);
      rd_code(8'h02, v); chk(v == 8'h00, "R10 flag cleared", v, 8'h00);
      wr_code(8'h09, 8'hC0);
      set_all(8'h5A);
      oneshot_wait();
      chk(alert_n == 1'b1, "R11 mask holds alert high", alert_n, 1);
      wr_code(8'h09, 8'h40);
      chk(alert_n == 1'b0, "R11 unmask shows alert", alert_n, 0);
      set_all(8'h28);
      oneshot_wait();
      rd_code(8'h02, v);
      rd_code(8'h02, v); chk(v == 8'h00, "R10 cleared before low test", v, 8'h00);
      wr_code(8'h0C, 8'h32);
      rd_code(8'h08, v); chk(v == 8'h32, "R4 low limit write", v, 8'h32);
      oneshot_wait();
      rd_code(8'h02, v); chk(v == 8'h08, "R9 lower flag", v, 8'h08);
      chk(alert_n == 1'b0, "R11 alert on lower breach", alert_n, 0);
      wr_code(8'h0C, 8'h00);
      rd_code(8'h02, v);
      chk(alert_n == 1'b1, "R10 lower flag released", alert_n, 1);
   endtask

   task automatic t_illegal();
      logic [7:0] v;
      wr_code(8'h01, 8'hAA);
      rd_code(8'h01, v); chk(v == 8'h28, "R4 write to temp ignored", v, 8'h28);
      wr_code(8'h07, 8'h00);
      rd_code(8'h07, v); chk(v == 8'h55, "R4 write to high read code ignored", v, 8'h55);
      wr_code(8'h05, 8'h12);
      rd_code(8'h03, v); chk(v == 8'h40, "R4 unmapped write ignored", v, 8'h40);
      rd_code(8'h09, v); chk(v == 8'hFF, "R3 write code reads fill", v, 8'hFF);
      rd_code(8'h0F, v); chk(v == 8'hFF, "R3 one-shot code reads fill", v, 8'hFF);
      rd_code(8'h05, v); chk(v == 8'hFF, "R3 unmapped read fill", v, 8'hFF);
      rd_code(8'h04, v); chk(v == 8'h27, "R3 state kept after odd reads", v, 8'h27);
      wr_code(8'h0B, 8'h60);
      rd_code(8'h07, v); chk(v == 8'h60, "R4 high limit write", v, 8'h60);
   endtask

   initial begin
      set_all(8'h20);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_period();
      t_channel();
      t_standby();
      t_busy();
      t_limits();
      t_illegal();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule